// File: doc/BRIEF.md
# Pixel Cache Tag Manager with Recency Replacement

This block keeps the tag side of a small, fully associative reference-pixel cache. The memory arbiter hands it one lookup at a time: a read or a write, a flag saying whether a read comes from the prefetcher or from the motion compensator, a byte address and a sub-identifier. The block drops the byte offset inside a 64-byte line and compares the remaining line tag against every stored tag in parallel.

For each accepted read it returns a single hit bit to the arbiter. It also issues at most one command to the separate pixel data store, carrying a line index and the sub-identifier. The command tells the store to reserve a line for incoming memory data, to hand out a resident line, to do both, or to discard a line. Replacement follows least-recently-used order, kept as one age counter per entry.

Outputs are registered. Both the response and the command leave from one output stage. When the data store cannot take a command, the block holds that stage and refuses new lookups.

Top module: `pcache_tag_mgr`

## Requirements
- R1: Two addresses that differ only in bits [5:0] select the same line; a read of the second one after the first hits.
- R2: Every accepted read produces `rsp_valid`=1 in the output stage loaded by it, with `rsp_hit`=1 on a hit and 0 on a miss; an accepted write produces `rsp_valid`=0.
- R3: A motion-compensation read (`req_pf`=0) that hits issues op 01 (hand out) with the index of the hit line and the request's sub-identifier.
- R4: A motion-compensation read that misses issues op 10 (reserve and hand out). Its index is the lowest-numbered empty entry, or the least-recently-used entry when none is empty.
- R5: A prefetch read (`req_pf`=1) that misses issues op 00 (reserve) and takes an entry chosen as in R4. A prefetch read that hits issues no command, yet moves that line to the most-recent position.
- R6: A write that hits issues op 11 (discard) with the line's index, empties that entry and removes it from the recency order. A write that misses issues no command and changes nothing.
- R7: Any read hit moves the line to most-recent, and a newly reserved line enters as most-recent. With all entries full, the victim is the least-recently-used line.
- R8: While `cmd_valid`=1 and `cmd_ready`=0, `req_ready` is 0 and all response and command outputs keep their values. Otherwise `req_ready` is 1 and the stage advances each cycle.
- R9: After reset, no entry is valid, `cmd_valid` and `rsp_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pf | input | 1 | For reads: 1 = prefetch source, 0 = motion compensation |
| req_addr | input | ADDR_W | Byte address |
| req_subid | input | SUBID_W | Sub-identifier passed through to the command |
| rsp_valid | output | 1 | Hit/miss response present for an accepted read |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| cmd_valid | output | 1 | Data-store command present |
| cmd_ready | input | 1 | Data store takes the command |
| cmd_op | output | 2 | 00 reserve, 01 hand out, 10 reserve and hand out, 11 discard |
| cmd_idx | output | IDX_W | Line index in the data store |
| cmd_subid | output | SUBID_W | Sub-identifier of the request |

## Verification
Two functions can act in the same cycle. A command can be stalled by the data store while the arbiter presents a new lookup, and that lookup could then be lost or applied twice to the recency order. The bench drives `cmd_ready` low at random while requests keep arriving. A behavioural queue model gives the expected output stage, `req_ready` and later victims, and these are compared every cycle. Evictions caused by a stalled-then-accepted request therefore show up as index mismatches on following allocations.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef enum logic [1:0] {
    OP_RESERVE      = 2'b00,
    OP_HANDOUT      = 2'b01,
    OP_RESERVE_HAND = 2'b10,
    OP_DISCARD      = 2'b11
  } store_op_e;
endpackage

// File: rtl/tcm_lookup.sv
module tcm_lookup #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int AGE_W   = IDX_W
) (
  input  logic [ENTRIES-1:0]            line_vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0] line_tag,
  input  logic [ENTRIES-1:0][AGE_W-1:0] line_age,
  input  logic [TAG_W-1:0]              probe_tag,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          free_any,
  output logic [IDX_W-1:0]              free_idx,
  output logic [IDX_W-1:0]              lru_idx
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] oldest;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]  = line_vld[g] && (line_tag[g] == probe_tag);
    assign oldest[g] = line_vld[g] && (line_age[g] == OLDEST);
  end

  always_comb begin
    hit      = |match;
    free_any = ~&line_vld;
    hit_idx  = '0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])     hit_idx  = IDX_W'(i);
      if (!line_vld[i]) free_idx = IDX_W'(i);
      if (oldest[i])    lru_idx  = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tcm_recency.sv
module tcm_recency #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int AGE_W   = IDX_W
) (
  input  logic [ENTRIES-1:0]            line_vld,
  input  logic [ENTRIES-1:0][AGE_W-1:0] age_q,
  input  logic                          promote,
  input  logic                          drop,
  input  logic [IDX_W-1:0]              sel,
  output logic [ENTRIES-1:0][AGE_W-1:0] age_d
);
  logic [AGE_W-1:0] sel_age;
  logic             sel_vld;

  assign sel_age = age_q[sel];
  assign sel_vld = line_vld[sel];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_comb begin
      age_d[g] = age_q[g];
      if (promote) begin
        if (IDX_W'(g) == sel)
          age_d[g] = '0;
        else if (line_vld[g] && (!sel_vld || (age_q[g] < sel_age)))
          age_d[g] = age_q[g] + AGE_W'(1);
      end else if (drop) begin
        if (line_vld[g] && (age_q[g] > sel_age))
          age_d[g] = age_q[g] - AGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/pcache_tag_mgr.sv
module pcache_tag_mgr
  import tcm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int SUBID_W = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_pf,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SUBID_W-1:0] req_subid,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_op,
  output logic [IDX_W-1:0]   cmd_idx,
  output logic [SUBID_W-1:0] cmd_subid
);
  localparam int LINE_BYTES = 64;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int TAG_W      = ADDR_W - OFF_W;
  localparam int AGE_W      = IDX_W;

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][AGE_W-1:0] age_q, age_d;

  logic [TAG_W-1:0]  probe_tag;
  logic [OFF_W-1:0]  line_off_unused;
  logic              hit, free_any;
  logic [IDX_W-1:0]  hit_idx, free_idx, lru_idx, tgt;
  logic              out_adv, accept;
  logic              promote, drop, set_line;

  logic              cv_d, rv_d, rh_d;
  store_op_e         op_d;
  logic [1:0]        op_q;

  assign probe_tag       = req_addr[ADDR_W-1:OFF_W];
  assign line_off_unused = req_addr[OFF_W-1:0];

  tcm_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_lookup (
    .line_vld (valid_q),
    .line_tag (tag_q),
    .line_age (age_q),
    .probe_tag(probe_tag),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .free_any (free_any),
    .free_idx (free_idx),
    .lru_idx  (lru_idx)
  );

  tcm_recency #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_recency (
    .line_vld(valid_q),
    .age_q   (age_q),
    .promote (promote),
    .drop    (drop),
    .sel     (tgt),
    .age_d   (age_d)
  );

  // Output stage advances unless a command is waiting on the store.
  assign out_adv   = !cmd_valid || cmd_ready;
  assign req_ready = out_adv;
  assign accept    = req_valid && out_adv;
  assign tgt       = hit ? hit_idx : (free_any ? free_idx : lru_idx);

  always_comb begin
    promote  = 1'b0;
    drop     = 1'b0;
    set_line = 1'b0;
    cv_d     = 1'b0;
    rv_d     = 1'b0;
    rh_d     = 1'b0;
    op_d     = OP_RESERVE;
    if (accept) begin
      if (req_write) begin
        if (hit) begin
          drop = 1'b1;
          cv_d = 1'b1;
          op_d = OP_DISCARD;
        end
      end else begin
        rv_d     = 1'b1;
        rh_d     = hit;
        promote  = 1'b1;
        set_line = !hit;
        if (req_pf) begin
          cv_d = !hit;
          op_d = OP_RESERVE;
        end else begin
          cv_d = 1'b1;
          op_d = hit ? OP_HANDOUT : OP_RESERVE_HAND;
        end
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (set_line) valid_d[tgt] = 1'b1;
    if (drop)     valid_d[tgt] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      cmd_valid <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      if (accept) valid_q <= valid_d;
      if (out_adv) begin
        cmd_valid <= cv_d;
        rsp_valid <= rv_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) age_q <= age_d;
    if (set_line) tag_q[tgt] <= probe_tag;
    if (out_adv) begin
      rsp_hit   <= rh_d;
      op_q      <= op_d;
      cmd_idx   <= tgt;
      cmd_subid <= req_subid;
    end
  end

  assign cmd_op = op_q;
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int ENTRIES = 8,
  parameter int SUBID_W = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_write,
  input logic                          rsp_valid,
  input logic                          rsp_hit,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic [1:0]                    cmd_op,
  input logic [IDX_W-1:0]              cmd_idx,
  input logic [SUBID_W-1:0]            cmd_subid,
  input logic [ENTRIES-1:0]            valid_q,
  input logic [ENTRIES-1:0][IDX_W-1:0] age_q
);
  logic ages_ok;
  always_comb begin
    int cnt;
    cnt     = $countones(valid_q);
    ages_ok = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && (int'(age_q[i]) >= cnt)) ages_ok = 1'b0;
      for (int j = i + 1; j < ENTRIES; j++)
        if (valid_q[i] && valid_q[j] && (age_q[i] == age_q[j])) ages_ok = 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_idx)
      && $stable(cmd_subid) && $stable(rsp_valid) && $stable(rsp_hit));

  assert_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |-> !req_ready);

  assert_read_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid);

  assert_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b11 |-> !rsp_valid);

  assert_handout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b01 |-> rsp_valid && rsp_hit);

  assert_miss_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'b10 |-> rsp_valid && !rsp_hit);

  assert_age_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ages_ok);
endmodule

bind pcache_tag_mgr tcm_checker #(.ENTRIES(ENTRIES), .SUBID_W(SUBID_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_idx(cmd_idx), .cmd_subid(cmd_subid), .valid_q(valid_q), .age_q(age_q)
);

// File: tb/sim_pcache_tag_mgr.sv
module sim_pcache_tag_mgr;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int IW = $clog2(N);

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, req_pf;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_subid;
  logic rsp_valid, rsp_hit, cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [IW-1:0] cmd_idx;
  logic [SW-1:0] cmd_subid;

  int checks = 0, fails = 0;

  pcache_tag_mgr #(.ENTRIES(N), .ADDR_W(AW), .SUBID_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_pf(req_pf), .req_addr(req_addr), .req_subid(req_subid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_subid(cmd_subid));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural model: slot table plus recency queue (front = most recent).
  int  m_tag[N];
  bit  m_vld[N];
  int  m_rec[$];
  bit  e_cv, e_rv, e_rh;
  int  e_op, e_idx, e_sub;

  function automatic void rec_remove(int s);
    for (int i = 0; i < m_rec.size(); i++)
      if (m_rec[i] == s) begin m_rec.delete(i); break; end
  endfunction

  function automatic void rec_front(int s);
    rec_remove(s);
    m_rec.push_front(s);
  endfunction

  function automatic int take_slot(int t);
    int s = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) s = i;
    if (s < 0) s = m_rec[m_rec.size() - 1];
    m_tag[s] = t;
    m_vld[s] = 1'b1;
    rec_front(s);
    return s;
  endfunction

  function automatic string op_req(int op);
    case (op)
      0: return "R5";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string rid, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rid, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(rsp_valid == e_rv, "R2", "rsp_valid", rsp_valid, e_rv);
    if (e_rv) chk(rsp_hit == e_rh, "R2", "rsp_hit", rsp_hit, e_rh);
    chk(cmd_valid == e_cv, e_cv ? op_req(e_op) : "R6", "cmd_valid", cmd_valid, e_cv);
    if (e_cv && cmd_valid) begin
      chk(int'(cmd_op) == e_op, op_req(e_op), "cmd_op", cmd_op, e_op);
      chk(int'(cmd_idx) == e_idx, "R7", "cmd_idx", cmd_idx, e_idx);
      chk(int'(cmd_subid) == e_sub, "R3", "cmd_subid", cmd_subid, e_sub);
    end
  endtask

  // Drive one cycle, predict, then compare after the edge.
  task automatic cycle(bit v, bit w, bit pf, int t, int off, int sub, bit cr);
    bit adv;
    req_valid = v; req_write = w; req_pf = pf;
    req_addr  = AW'((t << 6) | (off & 63));
    req_subid = SW'(sub);
    cmd_ready = cr;
    #1;
    adv = !e_cv || cr;
    chk(req_ready == adv, "R8", "req_ready", req_ready, adv);
    if (adv) begin
      e_cv = 0; e_rv = 0;
      if (v) begin
        int s = -1;
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == t) s = i;
        e_sub = sub;
        if (w) begin
          if (s >= 0) begin
            rec_remove(s); m_vld[s] = 0;
            e_cv = 1; e_op = 3; e_idx = s;
          end
        end else begin
          e_rv = 1; e_rh = (s >= 0);
          if (s >= 0) rec_front(s); else s = take_slot(t);
          e_idx = s;
          if (pf) begin e_cv = !e_rh; e_op = 0; end
          else    begin e_cv = 1; e_op = e_rh ? 1 : 2; end
        end
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_pf = 0;
    req_addr = '0; req_subid = '0; cmd_ready = 1;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
    e_cv = 0; e_rv = 0; e_rh = 0; e_op = 0; e_idx = 0; e_sub = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(cmd_valid == 0, "R9", "cmd_valid", cmd_valid, 0);
    chk(rsp_valid == 0, "R9", "rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R9", "req_ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // R4: fill empty entries in order
    for (int t = 0; t < N; t++) cycle(1, 0, 0, t, 0, t, 1);
    // R1: same line, other offset, must hit
    cycle(1, 0, 0, 0, 37, 5, 1);
    chk(rsp_hit == 1, "R1", "offset hit", rsp_hit, 1);
    // R7: full, new line evicts least recent (slot 1)
    cycle(1, 0, 0, 100, 0, 6, 1);
    chk(cmd_idx == 1, "R7", "victim", cmd_idx, 1);
    // R5: prefetch miss and prefetch hit
    cycle(1, 0, 1, 101, 0, 7, 1);
    cycle(1, 0, 1, 3, 9, 8, 1);
    chk(cmd_valid == 0, "R5", "pf hit no cmd", cmd_valid, 0);
    cycle(1, 0, 0, 102, 0, 9, 1);
    // R6: write hit discards, write miss silent, reread misses
    cycle(1, 1, 0, 0, 0, 10, 1);
    cycle(1, 1, 0, 0, 0, 11, 1);
    cycle(1, 0, 0, 0, 0, 12, 1);
    chk(rsp_hit == 0, "R6", "reread after discard", rsp_hit, 0);
    // R8: stall with requests waiting
    cycle(1, 0, 0, 5, 0, 13, 0);
    cycle(1, 0, 0, 200, 0, 14, 0);
    cycle(1, 0, 0, 200, 0, 14, 0);
    cycle(1, 0, 0, 200, 0, 14, 1);
    cycle(0, 0, 0, 0, 0, 0, 1);

    // Mixed traffic
    for (int k = 0; k < 5000; k++) begin
      bit v  = ($urandom % 10) < 7;
      bit w  = ($urandom % 4) == 0;
      bit pf = ($urandom % 3) == 0;
      bit cr = ($urandom % 4) != 0;
      cycle(v, w, pf, int'($urandom % (N + 5)), int'($urandom % 64), int'($urandom % 16), cr);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule